// File: doc/BRIEF.md
# SRAM controller with sub-word write wait state

This block is a single-port controller for an on-chip SRAM. It sits between a simple bus slave port and a word-wide storage array held inside the block. The port carries a request strobe, a read/write select, a byte address, a transfer size, write data and a ready reply. Each cycle in which the request is high and ready is high completes one transfer. A request must be held stable until ready goes high.

Reads, full-word writes and misaligned requests all complete in the cycle in which they are presented. A byte or halfword write needs a merge step in the array. When that write arrives in the cycle right after a completed read of the same memory block, ready is held low for one cycle. A block is the group of addresses that share the same upper address bits, and a parameter sets how many bits form that group. The read data is driven in the same cycle as ready. Byte lanes are little-endian.

Top module: `sram_subword_ctrl`

## Requirements
- R1: After reset, and in any cycle with `req` low, `ready` and `err` are low. Reset also forgets the last read, so a sub-word write issued right after reset gets no wait state.
- R2: An aligned read completes in the cycle it is presented. In that same cycle `rdata` holds the whole 32-bit word that contains the address.
- R3: A word write (`size`=2, `addr[1:0]`=0) completes with no wait state and stores all 32 bits of `wdata`.
- R4: A byte write (`size`=0) writes only lane `addr[1:0]`, taking its data from `wdata[7:0]`. Lane n is bits 8n+7..8n of the word, and the other lanes are left unchanged.
- R5: A halfword write (`size`=1, `addr[0]`=0) writes lanes 0-1 when `addr[1]`=0 and lanes 2-3 when `addr[1]`=1, taking its data from `wdata[15:0]`.
- R6: An aligned byte or halfword write that arrives in the cycle right after a completed, error-free read of the same block sees `ready` low for exactly one cycle and completes in the next cycle. The block is `addr[AW-1 -: BLK_BITS]`, and by default it is `addr[14:13]`.
- R7: A sub-word write gets no wait state in any of these cases: it targets a different block from the preceding read, an idle cycle separates it from that read, or the preceding read ended in an error.
- R8: A word write right after a read of the same block gets no wait state.
- R9: A misaligned request completes at once with `ready` and `err` both high, and it writes nothing. A misaligned request is one with `size`=3, a halfword with `addr[0]`=1, or a word with `addr[1:0]`≠0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Transfer request, held until ready |
| we | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| ready | output | 1 | Transfer completes this cycle |
| err | output | 1 | Error response, valid with ready |
| rdata | output | 32 | Read word, valid with ready |

## Verification
The bench targets the back-to-back read-then-write hazard from every side. It covers a stall in the same block, a different block, a separating idle cycle, a word write, a read that ended in an error, and a reset placed between the read and the write. A design that compared the wrong address bits, or that remembered the read for too long, would add or drop a wait cycle where the bench expects the opposite. Byte and halfword writes are read back lane by lane, so a swapped or shifted lane enable shows up as a corrupted neighbouring byte. Misaligned writes are followed by a read-back, so a design that wrote on an error would change the stored word.

// File: rtl/sram_subword_ctrl.sv
module sram_subword_ctrl #(
  parameter int DEPTH = 5120,
  parameter int BLK_BITS = 2,
  localparam int AW = $clog2(DEPTH * 4),
  localparam int WI = AW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [1:0]    size,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic          ready,
  output logic          err,
  output logic [31:0]   rdata
);

  logic [31:0] mem [DEPTH];
  logic [BLK_BITS-1:0] last_blk;
  logic rd_prev;
  logic [3:0] lane_en;
  logic [31:0] wlane;

  wire [WI-1:0] widx = addr[AW-1:2];
  wire in_range = int'(widx) < DEPTH;
  wire [BLK_BITS-1:0] blk = addr[AW-1 -: BLK_BITS];
  wire misal = (size == 2'd3) || (size == 2'd1 && addr[0]) || (size == 2'd2 && addr[1:0] != 2'b00);
  wire hazard = req && we && !size[1] && !misal && rd_prev && (blk == last_blk);

  assign ready = req && !hazard;
  assign err   = ready && misal;
  assign rdata = in_range ? mem[widx] : 32'h0;

  always_comb begin
    case (size)
      2'd0: begin
        lane_en = 4'b0001 << addr[1:0];
        wlane   = {4{wdata[7:0]}};
      end
      2'd1: begin
        lane_en = addr[1] ? 4'b1100 : 4'b0011;
        wlane   = {2{wdata[15:0]}};
      end
      default: begin
        lane_en = 4'b1111;
        wlane   = wdata;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (ready && we && !misal && in_range) begin
      for (int i = 0; i < 4; i++)
        if (lane_en[i]) mem[widx][8*i +: 8] <= wlane[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_prev  <= 1'b0;
      last_blk <= '0;
    end else begin
      rd_prev <= ready && !we && !misal;
      if (ready && !we && !misal) last_blk <= blk;
    end
  end

endmodule

module sram_subword_chk #(
  parameter int DEPTH = 5120,
  parameter int BLK_BITS = 2,
  localparam int AW = $clog2(DEPTH * 4)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [1:0]    size,
  input logic [AW-1:0] addr,
  input logic          ready,
  input logic          err
);

  wire bad = (size == 2'd3) || (size == 2'd1 && addr[0]) || (size == 2'd2 && addr[1:0] != 2'b00);
  wire rd_done = req && ready && !we && !bad;
  wire sub_wr = req && we && !size[1] && !bad;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (!ready && !err));

  assert_read_no_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we) |-> ready);

  assert_word_write_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && size == 2'd2 && addr[1:0] == 2'b00) |-> (ready && !err));

  assert_hazard_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> (!(sub_wr && addr[AW-1 -: BLK_BITS] == $past(addr[AW-1 -: BLK_BITS])) || !ready));

  assert_single_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ready) |=> (!req || ready));

  assert_error_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && bad) |-> (ready && err));

endmodule

bind sram_subword_ctrl sram_subword_chk #(.DEPTH(DEPTH), .BLK_BITS(BLK_BITS)) u_chk (.*);

// File: tb/tb_sram_subword_ctrl.sv
module tb_sram_subword_ctrl;
  localparam int DEPTH = 5120;
  localparam int AW = $clog2(DEPTH * 4);

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [1:0] size = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic ready, err;
  logic [31:0] rdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sram_subword_ctrl #(.DEPTH(DEPTH), .BLK_BITS(2)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .ready(ready), .err(err), .rdata(rdata));

  typedef struct packed {
    logic        idle;
    logic        w;
    logic [1:0]  sz;
    logic [15:0] a;
    logic [31:0] d;
    logic        ewait;
    logic        eerr;
    logic        chk;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,2'd2,16'h2000,32'hCAFEF00D,1'b0,1'b0,1'b0,32'h0},       // R3 block1 word
    '{1'b0,1'b1,2'd2,16'h0000,32'h11223344,1'b0,1'b0,1'b0,32'h0},       // R3
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h11223344},// R2
    '{1'b0,1'b1,2'd0,16'h0001,32'h000000AB,1'b1,1'b0,1'b0,32'h0},       // R6 byte stall
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h1122AB44},// R4
    '{1'b0,1'b1,2'd1,16'h0002,32'h00005566,1'b1,1'b0,1'b0,32'h0},       // R6 half stall
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h5566AB44},// R5 upper half
    '{1'b0,1'b1,2'd2,16'h0000,32'hA5A5A5A5,1'b0,1'b0,1'b0,32'h0},       // R8 word after read
    '{1'b0,1'b0,2'd2,16'h2000,32'h0,       1'b0,1'b0,1'b1,32'hCAFEF00D},// R2 block1
    '{1'b0,1'b1,2'd0,16'h0003,32'h00000077,1'b0,1'b0,1'b0,32'h0},       // R7 other block
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h77A5A5A5},// R4 lane3
    '{1'b1,1'b1,2'd0,16'h0000,32'h00000099,1'b0,1'b0,1'b0,32'h0},       // R7 idle between
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h77A5A599},// R4 lane0
    '{1'b0,1'b1,2'd1,16'h0001,32'h0000FFFF,1'b0,1'b1,1'b0,32'h0},       // R9 odd half
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h77A5A599},// R9 no write
    '{1'b0,1'b1,2'd2,16'h0002,32'hFFFFFFFF,1'b0,1'b1,1'b0,32'h0},       // R9 unaligned word
    '{1'b0,1'b1,2'd3,16'h0000,32'hFFFFFFFF,1'b0,1'b1,1'b0,32'h0},       // R9 invalid size
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h77A5A599},// R9 no write
    '{1'b0,1'b0,2'd1,16'h0003,32'h0,       1'b0,1'b1,1'b0,32'h0},       // R9 misaligned read
    '{1'b0,1'b1,2'd0,16'h0002,32'h0000003C,1'b0,1'b0,1'b0,32'h0},       // R7 after error read
    '{1'b0,1'b0,2'd2,16'h0000,32'h0,       1'b0,1'b0,1'b1,32'h773CA599},// R4 lane2
    '{1'b0,1'b0,2'd2,16'h2000,32'h0,       1'b0,1'b0,1'b1,32'hCAFEF00D},// R2
    '{1'b0,1'b1,2'd1,16'h2000,32'h00001234,1'b1,1'b0,1'b0,32'h0},       // R6 block1 stall
    '{1'b0,1'b0,2'd2,16'h2000,32'h0,       1'b0,1'b0,1'b1,32'hCAFE1234} // R5 lower half
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req = 1'b0;
    #1;
    check("R1 idle ready/err", {30'b0, ready, err}, 32'h0);
  endtask

  task automatic xfer(input vec_t v, input int idx);
    int waits = 0;
    @(negedge clk);
    req = 1'b1; we = v.w; size = v.sz; addr = v.a[AW-1:0]; wdata = v.d;
    #1;
    while (!ready && waits < 8) begin
      @(negedge clk);
      waits++;
      #1;
    end
    checks++;
    if (waits != int'(v.ewait)) begin
      fails++;
      $display("FAIL R6/R7 vec %0d wait cycles actual=%0d expected=%0d", idx, waits, v.ewait);
    end
    check($sformatf("R9 vec %0d err", idx), {31'b0, err}, {31'b0, v.eerr});
    if (v.chk) check($sformatf("R2 vec %0d rdata", idx), rdata, v.erd);
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 reset ready/err", {30'b0, ready, err}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].idle) idle_cycle();
      xfer(VECS[i], i);
    end
    idle_cycle();
    // R1: a read, then reset, then a sub-word write to the same block: no stall
    xfer('{1'b0,1'b0,2'd2,16'h0000,32'h0,1'b0,1'b0,1'b1,32'h773CA599}, 100);
    @(negedge clk);
    req = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after reset ready", {31'b0, ready}, 32'h0);
    xfer('{1'b0,1'b1,2'd0,16'h0001,32'h000000EE,1'b0,1'b0,1'b0,32'h0}, 101);
    xfer('{1'b0,1'b0,2'd2,16'h0000,32'h0,1'b0,1'b0,1'b1,32'h773CEE99}, 102);
    // R6: the stalled write is followed by another read and another stall
    xfer('{1'b0,1'b1,2'd1,16'h0000,32'h0000BEEF,1'b1,1'b0,1'b0,32'h0}, 103);
    xfer('{1'b0,1'b0,2'd2,16'h0000,32'h0,1'b0,1'b0,1'b1,32'h773CBEEF}, 104);
    idle_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule